// File: doc/BRIEF.md
# Power Sign Change Interrupt

This block tracks the sign of three summed-power channels and flags every sign reversal through a status register and an active-low interrupt pin. Each channel supplies a sign flag (1 = negative, 0 = positive) and the level of its frequency output pulse. The block looks at a channel's sign only when that channel's pulse goes from high to low. At that edge it records the sign in the sign register. If the recorded sign differs from the one recorded at that channel's previous falling edge, it also sets the channel's status bit. The sign bit and the status bit change in the same clock cycle.

Software enables interrupt sources through a mask register. When the interrupt pin goes low, software reads the status register and then the sign register to learn which channel reversed and in which direction. It clears the status bit by writing 1 to its position. Register contents are available on output ports. A two-way write port, selected by `wr_sel`, loads either the mask or the status write-one-to-clear path.

Top module: `psign_irq`

## Requirements
- R1: After a synchronous reset, the status, sign and mask words are all zero and `irq_n_o` is high.
- R2: A channel's sign bit takes the value of its `sign_i` bit only in a cycle where the channel's `pulse_i` bit was high on the previous clock and is low now. At all other times the sign bit holds, whatever `sign_i` and rising pulse edges do. Sign bits sit at word positions 3, 7 and 8 for channels 0, 1 and 2; 1 means negative.
- R3: On a falling pulse edge, if the newly captured sign differs from the sign captured at the channel's previous falling edge, the channel's status bit becomes 1 in the same cycle as the sign bit. Status bits sit at positions 9, 13 and 18 for channels 0, 1 and 2.
- R4: The first falling edge of a channel after reset captures its sign but never sets its status bit, even if the sign is negative.
- R5: A write with `wr_sel` = 0 loads the mask bits at positions 9, 13 and 18 from `wr_data`. The next cycle's `mask_o` shows them.
- R6: `irq_n_o` is low exactly when some status bit and its mask bit are both 1. It follows a status or mask change in the same cycle, so a masked reversal leaves the pin high.
- R7: A write with `wr_sel` = 1 clears every status bit whose position in `wr_data` holds 1. Status bits at positions holding 0 are unchanged.
- R8: When a reversal on a channel and a clearing write to that channel's status bit occur in the same cycle, the status bit ends up 1.
- R9: Status, mask and sign bits at positions other than those listed above always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_i | input | 3 | Frequency output pulse level per channel |
| sign_i | input | 3 | Summed-power sign per channel, 1 = negative |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = mask load, 1 = status write-one-to-clear |
| wr_data | input | W | Write data |
| status_o | output | W | Status word |
| sign_o | output | W | Sign word |
| mask_o | output | W | Mask word |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
The hardest case to reach from the ports is a reversal that lands in the same cycle as a clearing write to the same status bit. Getting there needs a channel that has already captured a sign once, a pulse that is high one cycle earlier, and then the falling edge, the opposite sign and the clearing write all applied together. A directed sequence builds that setup step by step. Random runs then keep toggling pulses while issuing frequent status writes, so the collision also appears with other channels changing at the same time. A bench model tracks the expected status, sign, mask and pin for every cycle.

// File: rtl/psign_pkg.sv
package psign_pkg;
  localparam int NCH = 3;

  // status word position of each channel
  function automatic int stat_bit(input int ch);
    case (ch)
      0:       return 9;
      1:       return 13;
      default: return 18;
    endcase
  endfunction

  // sign word position of each channel
  function automatic int sign_bit(input int ch);
    case (ch)
      0:       return 3;
      1:       return 7;
      default: return 8;
    endcase
  endfunction
endpackage

// File: rtl/psign_track.sv
// One channel: detects the pulse falling edge, captures the sign and
// reports a reversal against the previously captured sign.
module psign_track (
  input  logic clk,
  input  logic rst,
  input  logic pulse_i,
  input  logic sign_i,
  output logic fall_o,
  output logic chg_o,
  output logic sign_q_o
);
  logic pulse_d;
  logic sign_q;
  logic seen_q;

  assign fall_o   = pulse_d & ~pulse_i;
  assign chg_o    = fall_o & seen_q & (sign_q ^ sign_i);
  assign sign_q_o = sign_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_d <= 1'b0;
      sign_q  <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      pulse_d <= pulse_i;
      if (fall_o) begin
        sign_q <= sign_i;
        seen_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/psign_regs.sv
// Status (set on reversal, write-one-to-clear), mask and interrupt pin.
module psign_regs #(
  parameter int W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [psign_pkg::NCH-1:0] chg_i,
  input  logic                      wr_en,
  input  logic                      wr_sel,
  input  logic [W-1:0]              wr_data,
  output logic [W-1:0]              status_o,
  output logic [W-1:0]              mask_o,
  output logic                      irq_n_o
);
  import psign_pkg::*;

  logic [NCH-1:0] stat_q, stat_nxt;
  logic [NCH-1:0] mask_q, mask_nxt;
  logic           irq_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int SP = stat_bit(c);
    always_comb begin
      stat_nxt[c] = stat_q[c];
      if (wr_en && wr_sel && wr_data[SP]) stat_nxt[c] = 1'b0;
      if (chg_i[c])                       stat_nxt[c] = 1'b1;
      mask_nxt[c] = (wr_en && !wr_sel) ? wr_data[SP] : mask_q[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      mask_q <= '0;
      irq_q  <= 1'b1;
    end else begin
      stat_q <= stat_nxt;
      mask_q <= mask_nxt;
      irq_q  <= ~|(stat_nxt & mask_nxt);
    end
  end

  always_comb begin
    status_o = '0;
    mask_o   = '0;
    for (int c = 0; c < NCH; c++) begin
      status_o[stat_bit(c)] = stat_q[c];
      mask_o[stat_bit(c)]   = mask_q[c];
    end
  end

  assign irq_n_o = irq_q;
endmodule

// File: rtl/psign_irq.sv
module psign_irq #(
  parameter int W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [psign_pkg::NCH-1:0] pulse_i,
  input  logic [psign_pkg::NCH-1:0] sign_i,
  input  logic                      wr_en,
  input  logic                      wr_sel,
  input  logic [W-1:0]              wr_data,
  output logic [W-1:0]              status_o,
  output logic [W-1:0]              sign_o,
  output logic [W-1:0]              mask_o,
  output logic                      irq_n_o
);
  import psign_pkg::*;

  logic [NCH-1:0] fall, chg, sgn;

  for (genvar c = 0; c < NCH; c++) begin : g_trk
    psign_track u_trk (
      .clk      (clk),
      .rst      (rst),
      .pulse_i  (pulse_i[c]),
      .sign_i   (sign_i[c]),
      .fall_o   (fall[c]),
      .chg_o    (chg[c]),
      .sign_q_o (sgn[c])
    );
  end

  always_comb begin
    sign_o = '0;
    for (int c = 0; c < NCH; c++) sign_o[sign_bit(c)] = sgn[c];
  end

  psign_regs #(.W(W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .chg_i    (chg),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .status_o (status_o),
    .mask_o   (mask_o),
    .irq_n_o  (irq_n_o)
  );
endmodule

// File: rtl/psign_irq_chk.sv
module psign_irq_chk #(
  parameter int W = 32
) (
  input logic                      clk,
  input logic                      rst,
  input logic [psign_pkg::NCH-1:0] pulse_i,
  input logic                      wr_en,
  input logic                      wr_sel,
  input logic [W-1:0]              wr_data,
  input logic [W-1:0]              status_o,
  input logic [W-1:0]              sign_o,
  input logic [W-1:0]              mask_o,
  input logic                      irq_n_o
);
  import psign_pkg::*;

  logic [NCH-1:0] prev;
  logic [NCH-1:0] fall;
  logic [W-1:0]   smask, gmask;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= pulse_i;
  end
  assign fall = prev & ~pulse_i;

  always_comb begin
    smask = '0;
    gmask = '0;
    for (int c = 0; c < NCH; c++) begin
      smask[stat_bit(c)] = 1'b1;
      gmask[sign_bit(c)] = 1'b1;
    end
  end

  // R6
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq_n_o == ~|(status_o & mask_o));

  // R9
  spare_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((status_o & ~smask) == '0) && ((mask_o & ~smask) == '0) && ((sign_o & ~gmask) == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_a
    localparam int SP = stat_bit(c);
    localparam int GP = sign_bit(c);
    // R2
    sign_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !fall[c] |=> $stable(sign_o[GP]));
    // R3
    stat_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(status_o[SP]) |-> $past(fall[c]));
    // R7
    stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel && wr_data[SP] && !fall[c]) |=> !status_o[SP]);
  end
endmodule

bind psign_irq psign_irq_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pulse_i  (pulse_i),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .wr_data  (wr_data),
  .status_o (status_o),
  .sign_o   (sign_o),
  .mask_o   (mask_o),
  .irq_n_o  (irq_n_o)
);

// File: tb/tb_psign_irq.sv
`timescale 1ns/1ps
module tb_psign_irq;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   pulse_i = '0;
  logic [2:0]   sign_i = '0;
  logic         wr_en = 1'b0;
  logic         wr_sel = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] status_o, sign_o, mask_o;
  logic         irq_n_o;

  int checks = 0;
  int errors = 0;

  // model state
  bit m_pd[3], m_sg[3], m_seen[3], m_st[3], m_mk[3];

  always #4 clk = ~clk;

  psign_irq #(.W(W)) dut (.*);

  function automatic int spos(int c);
    return (c == 0) ? 9 : (c == 1) ? 13 : 18;
  endfunction
  function automatic int gpos(int c);
    return (c == 0) ? 3 : (c == 1) ? 7 : 8;
  endfunction
  function automatic logic [W-1:0] exp_status();
    logic [W-1:0] v = '0;
    for (int c = 0; c < 3; c++) v[spos(c)] = m_st[c];
    return v;
  endfunction
  function automatic logic [W-1:0] exp_mask();
    logic [W-1:0] v = '0;
    for (int c = 0; c < 3; c++) v[spos(c)] = m_mk[c];
    return v;
  endfunction
  function automatic logic [W-1:0] exp_sign();
    logic [W-1:0] v = '0;
    for (int c = 0; c < 3; c++) v[gpos(c)] = m_sg[c];
    return v;
  endfunction
  function automatic logic exp_irq();
    bit a = 0;
    for (int c = 0; c < 3; c++) a |= m_st[c] & m_mk[c];
    return ~a;
  endfunction

  task automatic check(string tag, string what, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic compare_all(string tag);
    check(tag, "status", status_o, exp_status());
    check(tag, "sign", sign_o, exp_sign());
    check(tag, "mask", mask_o, exp_mask());
    check(tag, "irq_n", W'(irq_n_o), W'(exp_irq()));
  endtask

  // apply one cycle of inputs, update the model, compare after the edge
  task automatic step(logic [2:0] p, logic [2:0] s, bit we, bit sel,
                      logic [W-1:0] d, string tag);
    pulse_i = p; sign_i = s; wr_en = we; wr_sel = sel; wr_data = d;
    for (int c = 0; c < 3; c++) begin
      bit fall, chg;
      fall = m_pd[c] & ~p[c];
      chg  = fall & m_seen[c] & (m_sg[c] != s[c]);
      if (fall) begin m_sg[c] = s[c]; m_seen[c] = 1; end
      m_pd[c] = p[c];
      if (we && sel && d[spos(c)]) m_st[c] = 0;
      if (chg) m_st[c] = 1;
      if (we && !sel) m_mk[c] = d[spos(c)];
    end
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    compare_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < 3; c++) begin
      m_pd[c] = 0; m_sg[c] = 0; m_seen[c] = 0; m_st[c] = 0; m_mk[c] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare_all("R1 reset");
    rst = 1'b0;

    // R4: first falling edges capture negative signs, no status
    step(3'b111, 3'b111, 0, 0, '0, "R4");
    step(3'b000, 3'b111, 0, 0, '0, "R4");
    // R2: sign input moves without a falling edge, including a rising edge
    step(3'b000, 3'b000, 0, 0, '0, "R2 hold low");
    step(3'b111, 3'b000, 0, 0, '0, "R2 rising");
    step(3'b111, 3'b101, 0, 0, '0, "R2 hold high");
    // R3: falling edge with reversed sign on all channels, mask off (R6)
    step(3'b000, 3'b000, 0, 0, '0, "R3 R6 masked");
    // R5 R6: enable channel 1 only, garbage elsewhere
    step(3'b000, 3'b000, 1, 0, 32'hFFF8_2000 & ~(32'h1 << 18) | 32'h0000_2000, "R5 R6");
    // R7: writing zeros leaves status
    step(3'b000, 3'b000, 1, 1, 32'h0000_0000, "R7 zero write");
    step(3'b000, 3'b000, 1, 1, 32'h0000_2000, "R7 R6 clear ch1");
    // R8: reversal on ch1 with simultaneous clear
    step(3'b010, 3'b000, 0, 0, '0, "R8 setup");
    step(3'b000, 3'b010, 1, 1, 32'hFFFF_FFFF, "R8 set wins");
    // R9: mask writes with all ones
    step(3'b000, 3'b010, 1, 0, 32'hFFFF_FFFF, "R9 R5");
    step(3'b000, 3'b010, 1, 1, 32'hFFFF_FFFF, "R7 R6 clear all");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] p, s;
      bit we, sel;
      logic [W-1:0] d;
      p   = 3'($urandom);
      s   = 3'($urandom);
      we  = ($urandom % 4) == 0;
      sel = $urandom % 2;
      d   = $urandom;
      step(p, s, we, sel, d, "R2 R3 R6 R7 R8 random");
    end

    // R1: reset mid-run
    rst = 1'b1;
    for (int c = 0; c < 3; c++) begin
      m_pd[c] = 0; m_sg[c] = 0; m_seen[c] = 0; m_st[c] = 0; m_mk[c] = 0;
    end
    @(posedge clk);
    @(negedge clk);
    compare_all("R1 rereset");
    rst = 1'b0;

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule